// File: doc/BRIEF.md
# Processor I/O Port Emulation

This block gives a processor that has no on-chip I/O port the two-register port it would otherwise carry at the very bottom of its address space. A full-width compare of the CPU address bus finds locations 0 and 1. Location 0 holds an 8-bit direction register and location 1 holds an 8-bit data register. Each port pin is driven from the data register when its direction bit is set and is left undriven otherwise. The port's read data goes straight onto the CPU data bus. Every other CPU transfer passes through an external memory data buffer, and this block supplies that buffer's active-low enable.

The buffer is shut off whenever the port is addressed, so RAM behind it stays silent. It is also shut off whenever the video controller takes the bus, which it signals by pulling bus-available low. The block also produces the two CPU clock phases from the input clock. It gates the CPU ready line with a run/halt control, so a test setup can freeze the processor.

A small bus-cycle state machine classifies each cycle at the rising edge of the second phase. The states are:
- `ST_IDLE`: the state after reset.
- `ST_MEM`: an ordinary memory cycle.
- `ST_PORT_RD`: a port read.
- `ST_PORT_WR`: a port write.
- `ST_VIDEO`: the video controller owns the bus.

From every state the next state depends only on the sampled bus:
- Bus-available low goes to `ST_VIDEO`.
- Otherwise a port address with write goes to `ST_PORT_WR`.
- A port address with read goes to `ST_PORT_RD`.
- Anything else goes to `ST_MEM`.

`ST_IDLE` is entered only through reset. In `ST_PORT_WR`, the addressed register loads at the following falling edge of the second phase. In `ST_PORT_RD`, the block drives the CPU data bus.

Top module: `cpu_port_glue`

## Requirements
- R1: `port_cs` is high only when every address bit above bit 0 is zero, that is, at address 0x000000 or 0x000001. `port_rs` equals the inverse of address bit 0: 1 selects the direction register (address 0) and 0 selects the data register (address 1).
- R2: `mem_buf_en_n` is low only when `aec` is high and `port_cs` is low. It is high whenever the port is addressed or `aec` is low.
- R3: `phi1` is the inverse of `clk_in`, and `phi2` is the inverse of `phi1`.
- R4: `cpu_rdy` is high exactly when both `board_rdy` and `run` are high. Dropping `run` halts the CPU.
- R5: After reset, the direction and data registers are zero. All pins are undriven (`pin_oe` = 0), and a read of address 1 returns `pin_in`.
- R6: In a cycle with `aec` high, `rw` low (write) and a port address, `cpu_wdata` loads into the addressed register at the falling edge of `phi2`. Address 0 loads the direction register and address 1 loads the data register.
- R7: `pin_oe` bit i equals direction bit i, and `pin_out` equals the data register.
- R8: A port read at address 0 returns the direction register. A port read at address 1 returns, per bit, the data register bit where the direction bit is 1 and `pin_in` where it is 0.
- R9: A port write issued while `aec` is low changes no register.
- R10: `port_drive` is high, and `cpu_rdata` carries port data, only in a port read cycle (port address, `rw` high, `aec` high). At all other times `cpu_rdata` is zero.
- R11: A non-port write, or a read at a port address, leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock from which both phases derive |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | CPU address bus |
| rw | input | 1 | CPU read/write, 1 = read |
| aec | input | 1 | Bus available to CPU, low when video owns the bus |
| cpu_wdata | input | PORT_W | CPU write data |
| board_rdy | input | 1 | Ready from the board |
| run | input | 1 | Run control, low halts the CPU |
| pin_in | input | PORT_W | Level sensed on port pins |
| phi1 | output | 1 | First clock phase |
| phi2 | output | 1 | Second clock phase |
| cpu_rdy | output | 1 | Gated CPU ready |
| port_cs | output | 1 | Port address decoded |
| port_rs | output | 1 | Register select, inverse of address bit 0 |
| mem_buf_en_n | output | 1 | Active-low memory data buffer enable |
| port_drive | output | 1 | Port drives the CPU data bus |
| cpu_rdata | output | PORT_W | Port read data toward the CPU |
| pin_out | output | PORT_W | Port pin output values |
| pin_oe | output | PORT_W | Port pin output enables |

## Verification
The hardest case to reach is a port write that arrives while the video controller holds the bus. The cycle must classify as `ST_VIDEO` even though address and write strobe both point at the port. The bench produces it by first loading known register values through ordinary writes. It then issues a write to location 1 with `aec` low and a different value. Finally it reads the register back through a normal port read and checks `pin_out` and `pin_oe`. The same read-back method exposes writes to a non-port address and reads of port locations that wrongly change a register.

// File: rtl/cpu_port_pkg.sv
package cpu_port_pkg;

    // Bus cycle classification, captured at the rising edge of phase two
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_MEM     = 3'd1,
        ST_PORT_RD = 3'd2,
        ST_PORT_WR = 3'd3,
        ST_VIDEO   = 3'd4
    } cyc_state_e;

    // Register select encoding: 1 = direction register, 0 = data register
    localparam logic RS_DIR  = 1'b1;
    localparam logic RS_DATA = 1'b0;

endpackage

// File: rtl/cpu_port_clkgen.sv
module cpu_port_clkgen (
    input  logic clk_in,
    input  logic board_rdy,
    input  logic run,
    output logic phi1,
    output logic phi2,
    output logic cpu_rdy
);

    // Phase one is the inverted input clock, phase two inverts phase one
    assign phi1    = ~clk_in;
    assign phi2    = ~phi1;

    // Ready is held off whenever the run control is dropped
    assign cpu_rdy = board_rdy & run;

endmodule

// File: rtl/cpu_port_decode.sv
module cpu_port_decode #(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              aec,
    output logic              port_cs,
    output logic              port_rs,
    output logic              mem_buf_en_n
);

    localparam int UPPER_W = ADDR_W - 1;

    logic [UPPER_W-1:0] upper_bits;

    assign upper_bits = addr[ADDR_W-1:1];

    // Full compare: every bit above bit zero must be clear
    assign port_cs = (upper_bits == '0);

    // Register select follows the inverted low address bit
    assign port_rs = ~addr[0];

    // Buffer enable is the NAND of "port not selected" and bus-available
    assign mem_buf_en_n = ~(~port_cs & aec);

endmodule

// File: rtl/cpu_port_regs.sv
module cpu_port_regs #(
    parameter int PORT_W = 8
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_rs,
    input  logic [PORT_W-1:0] wdata,
    input  logic              rd_rs,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] rd_value
);

    import cpu_port_pkg::*;

    logic [PORT_W-1:0] dir_q;
    logic [PORT_W-1:0] dat_q;
    logic [PORT_W-1:0] mixed;

    // Registers load at the falling edge of phase two (falling clk_in)
    always_ff @(negedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            dat_q <= '0;
        end else if (wr_en) begin
            if (wr_rs == RS_DIR) begin
                dir_q <= wdata;
            end else begin
                dat_q <= wdata;
            end
        end
    end

    // Per-pin drive and read-back selection
    generate
        for (genvar i = 0; i < PORT_W; i++) begin : g_pin
            assign pin_oe[i]  = dir_q[i];
            assign pin_out[i] = dat_q[i];
            assign mixed[i]   = dir_q[i] ? dat_q[i] : pin_in[i];
        end
    endgenerate

    assign rd_value = (rd_rs == RS_DIR) ? dir_q : mixed;

endmodule

// File: rtl/cpu_port_glue.sv
module cpu_port_glue #(
    parameter int ADDR_W = 24,
    parameter int PORT_W = 8
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic              aec,
    input  logic [PORT_W-1:0] cpu_wdata,
    input  logic              board_rdy,
    input  logic              run,
    input  logic [PORT_W-1:0] pin_in,
    output logic              phi1,
    output logic              phi2,
    output logic              cpu_rdy,
    output logic              port_cs,
    output logic              port_rs,
    output logic              mem_buf_en_n,
    output logic              port_drive,
    output logic [PORT_W-1:0] cpu_rdata,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);

    import cpu_port_pkg::*;

    cyc_state_e        state;
    cyc_state_e        state_nxt;
    cyc_state_e        cyc_class;
    logic              cyc_rs;
    logic              wr_en;
    logic [PORT_W-1:0] rd_value;

    cpu_port_clkgen u_clkgen (
        .clk_in    (clk_in),
        .board_rdy (board_rdy),
        .run       (run),
        .phi1      (phi1),
        .phi2      (phi2),
        .cpu_rdy   (cpu_rdy)
    );

    cpu_port_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr         (addr),
        .aec          (aec),
        .port_cs      (port_cs),
        .port_rs      (port_rs),
        .mem_buf_en_n (mem_buf_en_n)
    );

    // Classification of the bus as currently presented
    always_comb begin
        if (!aec) begin
            cyc_class = ST_VIDEO;
        end else if (port_cs && !rw) begin
            cyc_class = ST_PORT_WR;
        end else if (port_cs) begin
            cyc_class = ST_PORT_RD;
        end else begin
            cyc_class = ST_MEM;
        end
    end

    // Next-state selection
    always_comb begin
        unique case (state)
            ST_IDLE:    state_nxt = cyc_class;
            ST_MEM:     state_nxt = cyc_class;
            ST_PORT_RD: state_nxt = cyc_class;
            ST_PORT_WR: state_nxt = cyc_class;
            ST_VIDEO:   state_nxt = cyc_class;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    // State register: captured at the rising edge of phase two
    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cyc_rs <= RS_DATA;
        end else begin
            state  <= state_nxt;
            cyc_rs <= port_rs;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        unique case (state)
            ST_IDLE: begin
                port_drive = 1'b0;
                wr_en      = 1'b0;
            end
            ST_MEM: begin
                port_drive = 1'b0;
                wr_en      = 1'b0;
            end
            ST_PORT_RD: begin
                port_drive = 1'b1;
                wr_en      = 1'b0;
            end
            ST_PORT_WR: begin
                port_drive = 1'b0;
                wr_en      = 1'b1;
            end
            ST_VIDEO: begin
                port_drive = 1'b0;
                wr_en      = 1'b0;
            end
            default: begin
                port_drive = 1'b0;
                wr_en      = 1'b0;
            end
        endcase
    end

    cpu_port_regs #(
        .PORT_W (PORT_W)
    ) u_regs (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_rs    (cyc_rs),
        .wdata    (cpu_wdata),
        .rd_rs    (cyc_rs),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .rd_value (rd_value)
    );

    assign cpu_rdata = port_drive ? rd_value : '0;

endmodule

// File: rtl/cpu_port_glue_chk.sv
module cpu_port_glue_chk #(
    parameter int ADDR_W = 24,
    parameter int PORT_W = 8
) (
    input logic                      clk_in,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         addr,
    input logic                      aec,
    input logic                      board_rdy,
    input logic                      run,
    input logic                      cpu_rdy,
    input logic                      port_cs,
    input logic                      mem_buf_en_n,
    input logic [PORT_W-1:0]         pin_out,
    input logic [PORT_W-1:0]         pin_oe,
    input cpu_port_pkg::cyc_state_e  state
);

    import cpu_port_pkg::*;

    // R1
    cs_range_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        port_cs |-> (addr[ADDR_W-1:1] == '0));

    // R2
    buf_off_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        (port_cs || !aec) |-> mem_buf_en_n);

    // R4
    rdy_gate_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
        cpu_rdy |-> (board_rdy && run));

    // R9
    hold_regs_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
        (state != ST_PORT_WR) |=> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind cpu_port_glue cpu_port_glue_chk #(
    .ADDR_W (ADDR_W),
    .PORT_W (PORT_W)
) u_chk (
    .clk_in       (clk_in),
    .rst_n        (rst_n),
    .addr         (addr),
    .aec          (aec),
    .board_rdy    (board_rdy),
    .run          (run),
    .cpu_rdy      (cpu_rdy),
    .port_cs      (port_cs),
    .mem_buf_en_n (mem_buf_en_n),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .state        (state)
);

// File: tb/test_cpu_port_glue.sv
module test_cpu_port_glue;

    localparam int ADDR_W = 24;
    localparam int PORT_W = 8;

    logic              clk_in = 1'b0;
    logic              rst_n  = 1'b0;
    logic [ADDR_W-1:0] addr   = 24'h001234;
    logic              rw     = 1'b1;
    logic              aec    = 1'b1;
    logic [PORT_W-1:0] cpu_wdata = '0;
    logic              board_rdy = 1'b1;
    logic              run       = 1'b1;
    logic [PORT_W-1:0] pin_in    = 8'h5A;
    logic              phi1, phi2, cpu_rdy, port_cs, port_rs, mem_buf_en_n, port_drive;
    logic [PORT_W-1:0] cpu_rdata, pin_out, pin_oe;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    logic [PORT_W-1:0] rd_cap;
    logic              drv_cap;

    always #10 clk_in = ~clk_in;

    cpu_port_glue #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) i_cpu_port_glue (
        .clk_in(clk_in), .rst_n(rst_n), .addr(addr), .rw(rw), .aec(aec),
        .cpu_wdata(cpu_wdata), .board_rdy(board_rdy), .run(run), .pin_in(pin_in),
        .phi1(phi1), .phi2(phi2), .cpu_rdy(cpu_rdy), .port_cs(port_cs),
        .port_rs(port_rs), .mem_buf_en_n(mem_buf_en_n), .port_drive(port_drive),
        .cpu_rdata(cpu_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive after a falling edge, capture read data after
    // the rising edge, return just after the falling edge that writes.
    task automatic bus_cycle(input logic [ADDR_W-1:0] a, input logic r,
                             input logic [PORT_W-1:0] d, input logic av);
        @(negedge clk_in); #2;
        addr = a; rw = r; cpu_wdata = d; aec = av;
        @(posedge clk_in); #2;
        rd_cap  = cpu_rdata;
        drv_cap = port_drive;
        @(negedge clk_in); #1;
        addr = 24'h001234; rw = 1'b1; aec = 1'b1;
    endtask

    task automatic t_reset();
        check(pin_oe == 8'h00, "R5 pin_oe", pin_oe, 0);
        check(pin_out == 8'h00, "R5 pin_out", pin_out, 0);
        bus_cycle(24'h000001, 1'b1, 8'h00, 1'b1);
        check(rd_cap == 8'h5A, "R5 read data reg", rd_cap, 8'h5A);
        bus_cycle(24'h000000, 1'b1, 8'h00, 1'b1);
        check(rd_cap == 8'h00, "R5 read dir reg", rd_cap, 0);
    endtask

    task automatic t_decode();
        logic [ADDR_W-1:0] list [6] = '{24'h000000, 24'h000001, 24'h000002,
                                        24'h000100, 24'h010000, 24'h800001};
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 2; j++) begin
                @(negedge clk_in); #2;
                addr = list[i]; aec = j[0];
                #2;
                check(port_cs == (i < 2), "R1 port_cs", port_cs, i < 2);
                check(port_rs == ~list[i][0], "R1 port_rs", port_rs, ~list[i][0]);
                check(mem_buf_en_n == !(j[0] && i >= 2), "R2 mem_buf_en_n",
                      mem_buf_en_n, !(j[0] && i >= 2));
            end
        end
        aec = 1'b1; addr = 24'h001234;
    endtask

    task automatic t_clocks();
        @(posedge clk_in); #3;
        check(phi1 == 1'b0 && phi2 == 1'b1, "R3 clk high", {phi1, phi2}, 2'b01);
        @(negedge clk_in); #3;
        check(phi1 == 1'b1 && phi2 == 1'b0, "R3 clk low", {phi1, phi2}, 2'b10);
    endtask

    task automatic t_rdy();
        for (int k = 0; k < 4; k++) begin
            board_rdy = k[0]; run = k[1]; #1;
            check(cpu_rdy == (k == 3), "R4 cpu_rdy", cpu_rdy, k == 3);
        end
        board_rdy = 1'b1; run = 1'b1;
    endtask

    task automatic t_write_read();
        pin_in = 8'h3C;
        bus_cycle(24'h000000, 1'b0, 8'hF0, 1'b1);
        check(pin_oe == 8'hF0, "R6 R7 dir write", pin_oe, 8'hF0);
        check(pin_out == 8'h00, "R6 data untouched", pin_out, 0);
        bus_cycle(24'h000001, 1'b0, 8'hA5, 1'b1);
        check(pin_out == 8'hA5, "R6 R7 data write", pin_out, 8'hA5);
        bus_cycle(24'h000001, 1'b1, 8'h00, 1'b1);
        check(rd_cap == 8'hAC, "R8 mixed read", rd_cap, 8'hAC);
        check(drv_cap == 1'b1, "R10 drive on port read", drv_cap, 1);
        bus_cycle(24'h000000, 1'b1, 8'h00, 1'b1);
        check(rd_cap == 8'hF0, "R8 dir read", rd_cap, 8'hF0);
    endtask

    task automatic t_video_ignore();
        bus_cycle(24'h000001, 1'b0, 8'h11, 1'b0);
        check(pin_out == 8'hA5, "R9 data kept", pin_out, 8'hA5);
        bus_cycle(24'h000000, 1'b0, 8'h0F, 1'b0);
        check(pin_oe == 8'hF0, "R9 dir kept", pin_oe, 8'hF0);
        bus_cycle(24'h000001, 1'b1, 8'h00, 1'b0);
        check(drv_cap == 1'b0 && rd_cap == 8'h00, "R10 no drive video", rd_cap, 0);
    endtask

    task automatic t_other_cycles();
        bus_cycle(24'h000002, 1'b0, 8'h77, 1'b1);
        check(pin_out == 8'hA5 && pin_oe == 8'hF0, "R11 non-port write", pin_out, 8'hA5);
        bus_cycle(24'h000101, 1'b1, 8'h00, 1'b1);
        check(drv_cap == 1'b0 && rd_cap == 8'h00, "R10 memory read", rd_cap, 0);
        bus_cycle(24'h000001, 1'b1, 8'h66, 1'b1);
        check(pin_out == 8'hA5, "R11 port read keeps data", pin_out, 8'hA5);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        #35 rst_n = 1'b1;
        t_reset();
        t_decode();
        t_clocks();
        t_rdy();
        t_write_read();
        t_video_ignore();
        t_other_cycles();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule